// File: doc/BRIEF.md
# Twin-Form 8-Bit Maximal-Length Sequence Generator

This block holds two 8-bit maximal-length shift-register generators that are stepped together. One updates in the serial style: a parity over selected state bits is fed into the top of a right-shifting register. The other updates in the parallel style: the register shifts right, and the whole word is conditionally XORed with a constant. The two tap constants are bit-reversed images of each other, 0x1D for the serial form and 0xB8 for the parallel form. From the common start state 0x01 both generators emit the same bit stream, although the 8-bit states they pass through differ.

A sticky flag records any step on which the two emitted bits disagreed. The flag therefore acts as a running self-test of the pair. A seed can be loaded into both registers at once. A seed of zero would freeze both registers, so it is replaced by 0x01. Every output is registered. Each register's state is visible, and each output-bit register holds the bit emitted by the latest step.

Top module: `dual_lfsr_xcheck`

## Requirements
- R1: While `rst` is high at a rising edge, both states become 0x01, both output bits become 0 and `bits_differ` becomes 0.
- R2: On a step (`step_en`=1, `seed_ld`=0), the serial form emits the parity of (state AND 0x1D), where the taps are bits 0, 2, 3 and 4. Its state shifts right one place with that bit entering bit 7. `ser_bit` holds the emitted bit after the edge.
- R3: On a step, the parallel form emits state bit 0. Its state shifts right with a 0 entering bit 7 and is then XORed with 0xB8 (bits 3, 4, 5 and 7) if the emitted bit was 1. `par_bit` holds the emitted bit after the edge.
- R4: With `step_en`=0 and `seed_ld`=0, both states, both output bits and `bits_differ` hold their values.
- R5: When `seed_ld`=1, both states take `seed_val` at the edge, whatever `step_en` is. Both output bits clear to 0, and `bits_differ` is left unchanged.
- R6: A load with `seed_val`=0x00 puts 0x01 into both states.
- R7: Starting from state 0x01, the two emitted bits are equal on every one of 256 consecutive steps, and `bits_differ` stays 0. The two state sequences are not identical over those steps.
- R8: Each form returns to its start state after exactly 255 steps and never earlier, and neither state is ever 0x00.
- R9: `bits_differ` becomes 1 at the edge of the first step on which the two emitted bits differ. It then stays 1 through steps, holds and loads until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance both generators one step |
| seed_ld | input | 1 | Load `seed_val` into both generators (wins over `step_en`) |
| seed_val | input | 8 | Seed value; zero is replaced by 0x01 |
| ser_state | output | 8 | Serial-form register state |
| par_state | output | 8 | Parallel-form register state |
| ser_bit | output | 1 | Bit emitted by the serial form on the latest step |
| par_bit | output | 1 | Bit emitted by the parallel form on the latest step |
| bits_differ | output | 1 | Sticky flag: the emitted bits disagreed at least once |

## Verification
The hard case is the disagreement flag. From reset the two forms agree by design, so the flag cannot be set with the reset seed. The stimulus searches, inside the bench's own models of both update rules, for the first seed whose two streams diverge within a few steps. It then loads that seed into the design and steps it. The flag must rise on the exact step the models predict, and must survive a later reload of 0x01 and a hold until reset clears it.

// File: rtl/dual_lfsr_pkg.sv
package dual_lfsr_pkg;
  typedef enum logic {
    FORM_SERIAL   = 1'b0,
    FORM_PARALLEL = 1'b1
  } lfsr_form_e;

  localparam int unsigned LFSR_W = 8;
endpackage

// File: rtl/lfsr_core.sv
module lfsr_core
  import dual_lfsr_pkg::*;
#(
  parameter int unsigned   W         = 8,
  parameter lfsr_form_e    FORM      = FORM_SERIAL,
  parameter logic [W-1:0]  TAPS      = 8'h1D,
  parameter logic [W-1:0]  RESET_VAL = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] state_o,
  output logic         bit_o,
  output logic         emit_o
);
  logic [W-1:0] nxt;
  logic         emit;

  generate
    if (FORM == FORM_SERIAL) begin : g_ser
      always_comb begin
        emit = ^(state_o & TAPS);
        nxt  = {emit, state_o[W-1:1]};
      end

      // R2
      ser_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (state_o[W-2:0] == $past(state_o[W-1:1])));
    end else begin : g_par
      always_comb begin
        emit = state_o[0];
        nxt  = (state_o >> 1) ^ (emit ? TAPS : {W{1'b0}});
      end

      // R3
      par_plain_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !state_o[0]) |=> (state_o == ($past(state_o) >> 1)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= RESET_VAL;
      bit_o   <= 1'b0;
    end else if (load) begin
      state_o <= load_val;
      bit_o   <= 1'b0;
    end else if (step) begin
      state_o <= nxt;
      bit_o   <= emit;
    end
  end

  assign emit_o = emit;

  // R4
  core_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> ($stable(state_o) && $stable(bit_o)));

  // R8
  core_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o != {W{1'b0}}));
endmodule

// File: rtl/mismatch_tracker.sv
module mismatch_tracker (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic bit_a,
  input  logic bit_b,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (step && (bit_a != bit_b))
      flag <= 1'b1;
  end

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag |=> flag);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (step && (bit_a != bit_b)) |=> flag);
endmodule

// File: rtl/dual_lfsr_xcheck.sv
module dual_lfsr_xcheck
  import dual_lfsr_pkg::*;
#(
  parameter int unsigned          W         = LFSR_W,
  parameter logic [LFSR_W-1:0]    SER_TAPS  = 8'h1D,
  parameter logic [LFSR_W-1:0]    PAR_TAPS  = 8'hB8,
  parameter logic [LFSR_W-1:0]    START_VAL = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         seed_ld,
  input  logic [W-1:0] seed_val,
  output logic [W-1:0] ser_state,
  output logic [W-1:0] par_state,
  output logic         ser_bit,
  output logic         par_bit,
  output logic         bits_differ
);
  localparam logic [W-1:0] ZERO = {W{1'b0}};

  logic [W-1:0] safe_seed;
  logic         do_step;
  logic         ser_emit;
  logic         par_emit;

  assign safe_seed = (seed_val == ZERO) ? START_VAL : seed_val;
  assign do_step   = step_en & ~seed_ld;

  lfsr_core #(
    .W(W), .FORM(FORM_SERIAL), .TAPS(SER_TAPS), .RESET_VAL(START_VAL)
  ) u_ser (
    .clk(clk), .rst(rst), .step(do_step), .load(seed_ld),
    .load_val(safe_seed), .state_o(ser_state), .bit_o(ser_bit),
    .emit_o(ser_emit)
  );

  lfsr_core #(
    .W(W), .FORM(FORM_PARALLEL), .TAPS(PAR_TAPS), .RESET_VAL(START_VAL)
  ) u_par (
    .clk(clk), .rst(rst), .step(do_step), .load(seed_ld),
    .load_val(safe_seed), .state_o(par_state), .bit_o(par_bit),
    .emit_o(par_emit)
  );

  mismatch_tracker u_track (
    .clk(clk), .rst(rst), .step(do_step),
    .bit_a(ser_emit), .bit_b(par_emit), .flag(bits_differ)
  );

  // R5
  load_same_chk: assert property (@(posedge clk) disable iff (rst)
    seed_ld |=> (ser_state == par_state) && !ser_bit && !par_bit);

  // R6
  load_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_ld && (seed_val == ZERO)) |=> (ser_state == START_VAL));

  // R7
  start_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (!bits_differ && $past(!bits_differ)) |-> (ser_bit == par_bit));
endmodule

// File: tb/dual_lfsr_xcheck_bench.sv
`timescale 1ns/1ps
module dual_lfsr_xcheck_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic       seed_ld = 1'b0;
  logic [7:0] seed_val = 8'h00;
  logic [7:0] ser_state, par_state;
  logic       ser_bit, par_bit, bits_differ;

  always #10 clk = ~clk;

  dual_lfsr_xcheck u_dual_lfsr_xcheck (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_ld(seed_ld),
    .seed_val(seed_val), .ser_state(ser_state), .par_state(par_state),
    .ser_bit(ser_bit), .par_bit(par_bit), .bits_differ(bits_differ)
  );

  typedef struct {
    logic [7:0] s_st;
    logic [7:0] p_st;
    logic       s_b;
    logic       p_b;
    logic       mm;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_s, m_p;
  logic       m_sb, m_pb, m_mm;

  function automatic logic ser_out(logic [7:0] s);
    logic r = 1'b0;
    if (s[0]) r = ~r;
    if (s[2]) r = ~r;
    if (s[3]) r = ~r;
    if (s[4]) r = ~r;
    return r;
  endfunction

  function automatic logic [7:0] ser_nx(logic [7:0] s);
    return {ser_out(s), s[7:1]};
  endfunction

  function automatic logic [7:0] par_nx(logic [7:0] s);
    logic [7:0] t = {1'b0, s[7:1]};
    if (s[0]) t = t ^ 8'b1011_1000;
    return t;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit e, bit l, logic [7:0] sv, string tag);
    exp_t x;
    logic so, po;
    @(negedge clk);
    rst = r; step_en = e; seed_ld = l; seed_val = sv;
    if (r) begin
      m_s = 8'h01; m_p = 8'h01; m_sb = 0; m_pb = 0; m_mm = 0;
    end else if (l) begin
      m_s = (sv == 0) ? 8'h01 : sv; m_p = m_s; m_sb = 0; m_pb = 0;
    end else if (e) begin
      so = ser_out(m_s); po = m_p[0];
      if (so != po) m_mm = 1;
      m_s = ser_nx(m_s); m_p = par_nx(m_p); m_sb = so; m_pb = po;
    end
    x.s_st = m_s; x.p_st = m_p; x.s_b = m_sb; x.p_b = m_pb; x.mm = m_mm; x.tag = tag;
    q.push_back(x);
    @(posedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk(ser_state == x.s_st, x.tag, "ser_state", ser_state, x.s_st);
      chk(par_state == x.p_st, x.tag, "par_state", par_state, x.p_st);
      chk(ser_bit == x.s_b, x.tag, "ser_bit", ser_bit, x.s_b);
      chk(par_bit == x.p_b, x.tag, "par_bit", par_bit, x.p_b);
      chk(bits_differ == x.mm, x.tag, "bits_differ", bits_differ, x.mm);
    end
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ser_ret, par_ret, diff_steps, zero_seen, bit_neq, div_seed;
    logic [7:0] a, b;
    ser_ret = 0; par_ret = 0; diff_steps = 0; zero_seen = 0; bit_neq = 0;

    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 8'h00, "R1");

    // R2 R3 R7 R8: 256 steps from 0x01
    for (int i = 1; i <= 256; i++) begin
      cyc(0, 1, 0, 8'h00, "R7");
      #2;
      if (ser_state != par_state) diff_steps++;
      if (ser_bit != par_bit) bit_neq++;
      if (ser_state == 0 || par_state == 0) zero_seen++;
      if (ser_state == 8'h01 && ser_ret == 0) ser_ret = i;
      if (par_state == 8'h01 && par_ret == 0) par_ret = i;
    end
    chk(bit_neq == 0, "R7", "unequal_bit_steps", bit_neq, 0);
    chk(diff_steps > 0, "R7", "state_seq_differs", diff_steps, 1);
    chk(ser_ret == 255, "R8", "serial_period", ser_ret, 255);
    chk(par_ret == 255, "R8", "parallel_period", par_ret, 255);
    chk(zero_seen == 0, "R8", "zero_state_seen", zero_seen, 0);

    // R2 R3 on a few specific steps from seed 0x5A
    cyc(0, 0, 1, 8'h5A, "R5");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 8'h00, "R2");

    // R4: hold
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 8'hFF, "R4");

    // R6 with enable high (R5 priority)
    cyc(0, 1, 1, 8'h00, "R6");
    #2;
    chk(ser_state == 8'h01 && par_state == 8'h01, "R6", "zero_seed_state", ser_state, 1);
    cyc(0, 1, 0, 8'h00, "R3");

    // R9: find a diverging seed with the bench models
    div_seed = 0;
    for (int s = 2; s < 256 && div_seed == 0; s++) begin
      a = s[7:0]; b = s[7:0];
      for (int k = 0; k < 12; k++) begin
        if (ser_out(a) != b[0] && div_seed == 0) div_seed = s;
        a = ser_nx(a); b = par_nx(b);
      end
    end
    chk(div_seed != 0, "R9", "diverging_seed_found", div_seed, 1);
    cyc(0, 1, 1, div_seed[7:0], "R5");
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 8'h00, "R9");
    #2;
    chk(bits_differ == 1'b1, "R9", "flag_after_divergence", bits_differ, 1);

    // R9: sticky across reload of 0x01 and hold
    cyc(0, 0, 1, 8'h01, "R9");
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 8'h00, "R9");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 8'h00, "R9");
    #2;
    chk(bits_differ == 1'b1, "R9", "flag_sticky", bits_differ, 1);

    // R1: reset clears flag
    cyc(1, 0, 0, 8'h00, "R1");
    cyc(0, 0, 0, 8'h00, "R1");
    #2;
    chk(bits_differ == 1'b0, "R1", "flag_after_reset", bits_differ, 0);

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule